// File: doc/BRIEF.md
# Shift and Rotate Execution Unit with Carry

This unit performs the bit-moving operations of an integer datapath on a 32-bit register operand. Each request gives an operand, a three-bit operation code, an operand size (8, 16 or 32 bits), the incoming carry, zero and sign flags, and a shift count. The count is taken either from an immediate field or from the low byte of a count register. The unit returns the new operand value and the new carry, zero and sign flags one clock after the request.

Eight operations are supported. There are left shifts that fill with zero, right shifts that fill with zero, right shifts that copy the sign, rotates inside the operand, and rotates that carry the flag along as one extra bit. The count is reduced to its low five bits. Bits of the 32-bit word above the selected size are never modified. Shifts recompute all three flags. Rotates change only the carry.

Top module: `shift_rot_unit`

## Requirements
- R1: A request with `inValid` high gives `outValid` high on the next clock, with the result and flags of that request. When `inValid` is low, `outValid` goes low on the next clock and the result and flags keep their values.
- R2: Codes 4 and 6 shift left. Zeros enter at bit 0. The carry is the last bit shifted out: bit W−n of the operand (W is the size, n the count), or 0 when n exceeds W.
- R3: Code 5 shifts right with zero fill. The carry is operand bit n−1, or 0 when n exceeds W.
- R4: Code 7 shifts right and copies bit W−1 into the vacated bits. The carry is the last bit shifted out, which is the sign bit when n is W or more.
- R5: Code 0 rotates left and code 1 rotates right, within W bits, by n modulo W. The carry becomes result bit 0 after a left rotate and result bit W−1 after a right rotate.
- R6: Code 2 rotates left and code 3 rotates right through a W+1-bit ring. The carry sits above bit W−1 of that ring. The rotate amount is n modulo W+1, so a reduced amount of zero leaves both the operand and the carry as they were.
- R7: After a shift, the zero flag is set exactly when the low W result bits are all zero, and the sign flag equals result bit W−1.
- R8: After a rotate (codes 0 to 3), the zero and sign flags equal `zeroIn` and `signIn`.
- R9: `countSel` = 0 takes the count from `countImm`. `countSel` = 1 takes it from `countRegLow`. Only the low five bits of the selected byte are used.
- R10: When the five-bit count is zero, the result equals the operand and all three flags equal their inputs, whatever the operation.
- R11: `sizeSel` selects the size: 0 is 8 bits, 1 is 16 bits, 2 or 3 is 32 bits. Result bits at or above W equal the operand bits there.
- R12: While reset is asserted, and afterwards until the first request, `outValid`, `result` and all three flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request strobe |
| opCode | input | 3 | Operation code (R2–R6) |
| sizeSel | input | 2 | Operand size code (R11) |
| operand | input | 32 | Value to shift or rotate |
| carryIn | input | 1 | Current carry flag |
| zeroIn | input | 1 | Current zero flag |
| signIn | input | 1 | Current sign flag |
| countSel | input | 1 | Count source: 0 immediate, 1 register |
| countImm | input | 8 | Immediate count |
| countRegLow | input | 8 | Low byte of the count register |
| outValid | output | 1 | Result strobe |
| result | output | 32 | Shifted or rotated value |
| carryOut | output | 1 | New carry flag |
| zeroOut | output | 1 | New zero flag |
| signOut | output | 1 | New sign flag |

## Verification
The decode is held in a single strobe word, and the output registers load in the cycle after the request. A wrong decoded field therefore shows up at the ports exactly one clock later. A wrong ring period or modulo reduction gives a wrong carry or a wrong low bit at counts such as 9 on a byte or 20 on a word. A wrong size mask either corrupts the upper bits or makes the zero and sign flags follow the wrong bit. A wrong fill selection changes the bits that enter an arithmetic right shift. Each of these errors is visible on the very next `outValid` pulse, so the vectors are chosen to cross each size at counts below, equal to and above the operand width.

// File: rtl/srot_pkg.sv
package srot_pkg;
  localparam int DATA_W   = 32;
  localparam int CNT_W    = $clog2(DATA_W);
  localparam int WID_W    = CNT_W + 2;
  localparam int RC_STEPS = (DATA_W - 1) / 9;

  typedef enum logic [2:0] {
    OP_ROL = 3'd0, OP_ROR = 3'd1, OP_RCL = 3'd2, OP_RCR = 3'd3,
    OP_SHL = 3'd4, OP_SHR = 3'd5, OP_SAL = 3'd6, OP_SAR = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    CLS_ROT = 2'd0, CLS_RC = 2'd1, CLS_SHL = 2'd2, CLS_SHR = 2'd3
  } cls_e;

  typedef struct packed {
    logic             load;
    logic             passAll;
    cls_e             opClass;
    logic             toRight;
    logic             arith;
    logic [WID_W-1:0] width;
    logic [CNT_W-1:0] shAmt;
    logic [CNT_W:0]   rcAmt;
  } strobe_t;
endpackage

// File: rtl/srot_ctrl.sv
module srot_ctrl
  import srot_pkg::*;
(
  input  logic       inValid,
  input  logic [2:0] opCode,
  input  logic [1:0] sizeSel,
  input  logic       countSel,
  input  logic [7:0] countImm,
  input  logic [7:0] countRegLow,
  output strobe_t    strobes
);
  op_e              op;
  logic [7:0]       rawCount;
  logic [CNT_W-1:0] maskedCount;
  logic [WID_W-1:0] width;
  logic [WID_W-1:0] period;
  logic [CNT_W:0]   rcMod;
  logic [WID_W-1:0] rcBack;
  logic             unusedCountBits;

  assign unusedCountBits = ^rawCount[7:CNT_W];

  always_comb begin
    op          = op_e'(opCode);
    rawCount    = countSel ? countRegLow : countImm;
    maskedCount = rawCount[CNT_W-1:0];
    if (sizeSel == 2'd0)      width = WID_W'(8);
    else if (sizeSel == 2'd1) width = WID_W'(16);
    else                      width = WID_W'(DATA_W);
    period = width + WID_W'(1);

    // reduce the count modulo the ring length used by carry rotates
    rcMod = {1'b0, maskedCount};
    for (int s = 0; s < RC_STEPS; s++) begin
      if ({1'b0, rcMod} >= period) rcMod = rcMod - period[CNT_W:0];
    end
    rcBack = period - {1'b0, rcMod};

    strobes.load    = inValid;
    strobes.passAll = (maskedCount == '0);
    strobes.width   = width;
    strobes.shAmt   = maskedCount;
    strobes.toRight = (op == OP_ROR);
    strobes.arith   = (op == OP_SAR);
    strobes.rcAmt   = rcMod;
    if (op == OP_RCR && rcMod != '0) strobes.rcAmt = rcBack[CNT_W:0];
    unique case (op)
      OP_ROL, OP_ROR: strobes.opClass = CLS_ROT;
      OP_RCL, OP_RCR: strobes.opClass = CLS_RC;
      OP_SHL, OP_SAL: strobes.opClass = CLS_SHL;
      default:        strobes.opClass = CLS_SHR;
    endcase
  end
endmodule

// File: rtl/srot_dpath.sv
module srot_dpath
  import srot_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] operand,
  input  logic              carryIn,
  input  logic              zeroIn,
  input  logic              signIn,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              zeroOut,
  output logic              signOut
);
  logic [DATA_W-1:0]   sizeMask, val, extVal, rep, res, merged;
  logic [2*DATA_W-1:0] leftWide, rotWide;
  logic [2*DATA_W:0]   rightWide;
  logic [DATA_W:0]     rcSrc, rcLo, rcHi, rcAll, rcMask;
  logic [WID_W-1:0]    hiShift;
  logic [CNT_W:0]      lIdx;
  logic [CNT_W-1:0]    topIdx;
  logic                msb, fillBit, isShift, cfNew, zfNew, sfNew;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) sizeMask[i] = (WID_W'(i) < strobes.width);
    for (int i = 0; i <= DATA_W; i++) rcMask[i] = (WID_W'(i) <= strobes.width);
    lIdx    = strobes.width[CNT_W:0];
    topIdx  = strobes.width[CNT_W-1:0] - CNT_W'(1);
    val     = operand & sizeMask;
    msb     = operand[topIdx];
    fillBit = strobes.arith & msb;
    extVal  = val | ({DATA_W{fillBit}} & ~sizeMask);

    leftWide  = {{DATA_W{1'b0}}, val} << strobes.shAmt;
    rightWide = {{DATA_W{fillBit}}, extVal, 1'b0} >> strobes.shAmt;

    // replicate the active field so a 32-bit rotate acts modulo its width
    if (strobes.width == WID_W'(8))       rep = {(DATA_W/8){val[7:0]}};
    else if (strobes.width == WID_W'(16)) rep = {(DATA_W/16){val[15:0]}};
    else                                  rep = val;
    rotWide = strobes.toRight ? ({rep, rep} >> strobes.shAmt)
                              : ({rep, rep} << strobes.shAmt);

    rcSrc       = {1'b0, val};
    rcSrc[lIdx] = carryIn;
    rcLo        = rcSrc << strobes.rcAmt;
    hiShift     = strobes.width + WID_W'(1) - {1'b0, strobes.rcAmt};
    rcHi        = rcSrc >> hiShift;
    rcAll       = (rcLo | rcHi) & rcMask;

    res   = '0;
    cfNew = carryIn;
    unique case (strobes.opClass)
      CLS_SHL: begin res = leftWide[DATA_W-1:0]; cfNew = leftWide[lIdx]; end
      CLS_SHR: begin res = rightWide[DATA_W:1];  cfNew = rightWide[0];   end
      CLS_ROT: begin
        if (strobes.toRight) begin
          res = rotWide[DATA_W-1:0];  cfNew = res[topIdx];
        end else begin
          res = rotWide[2*DATA_W-1:DATA_W]; cfNew = res[0];
        end
      end
      default: begin res = rcAll[DATA_W-1:0]; cfNew = rcAll[lIdx]; end
    endcase

    merged  = (operand & ~sizeMask) | (res & sizeMask);
    isShift = (strobes.opClass == CLS_SHL) || (strobes.opClass == CLS_SHR);
    zfNew   = isShift ? ((res & sizeMask) == '0) : zeroIn;
    sfNew   = isShift ? merged[topIdx] : signIn;
    if (strobes.passAll) begin
      merged = operand; cfNew = carryIn; zfNew = zeroIn; sfNew = signIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      carryOut <= 1'b0;
      zeroOut  <= 1'b0;
      signOut  <= 1'b0;
    end else begin
      outValid <= strobes.load;
      if (strobes.load) begin
        result   <= merged;
        carryOut <= cfNew;
        zeroOut  <= zfNew;
        signOut  <= sfNew;
      end
    end
  end
endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit
  import srot_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [2:0]        opCode,
  input  logic [1:0]        sizeSel,
  input  logic [DATA_W-1:0] operand,
  input  logic              carryIn,
  input  logic              zeroIn,
  input  logic              signIn,
  input  logic              countSel,
  input  logic [7:0]        countImm,
  input  logic [7:0]        countRegLow,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              zeroOut,
  output logic              signOut
);
  strobe_t strobes;

  srot_ctrl u_ctrl (
    .inValid(inValid), .opCode(opCode), .sizeSel(sizeSel),
    .countSel(countSel), .countImm(countImm), .countRegLow(countRegLow),
    .strobes(strobes)
  );

  srot_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .operand(operand),
    .carryIn(carryIn), .zeroIn(zeroIn), .signIn(signIn),
    .outValid(outValid), .result(result), .carryOut(carryOut),
    .zeroOut(zeroOut), .signOut(signOut)
  );
endmodule

// File: rtl/srot_checker.sv
module srot_checker
  import srot_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [2:0]        opCode,
  input logic [1:0]        sizeSel,
  input logic [DATA_W-1:0] operand,
  input logic              carryIn,
  input logic              zeroIn,
  input logic              signIn,
  input logic              countSel,
  input logic [7:0]        countImm,
  input logic [7:0]        countRegLow,
  input logic              outValid,
  input logic [DATA_W-1:0] result,
  input logic              carryOut,
  input logic              zeroOut,
  input logic              signOut
);
  logic [CNT_W-1:0] cntSeen;
  logic             cntZero;
  assign cntSeen = countSel ? countRegLow[CNT_W-1:0] : countImm[CNT_W-1:0];
  assign cntZero = (cntSeen == '0);

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_idle_holds_R1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(result) && $stable(carryOut)));
  assert_shl_zero_fill_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (opCode == 3'd4) && !cntZero) |=> !result[0]);
  assert_rotate_flags_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !opCode[2]) |=> (zeroOut == $past(zeroIn) && signOut == $past(signIn)));
  assert_dword_shift_flags_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode[2] && sizeSel[1] && !cntZero)
      |=> (zeroOut == (result == '0) && signOut == result[DATA_W-1]));
  assert_zero_count_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && cntZero) |=> (result == $past(operand) && carryOut == $past(carryIn)
                              && zeroOut == $past(zeroIn) && signOut == $past(signIn)));
  assert_byte_upper_R11: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && sizeSel == 2'd0) |=> (result[DATA_W-1:8] == $past(operand[DATA_W-1:8])));
  assert_word_upper_R11: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && sizeSel == 2'd1) |=> (result[DATA_W-1:16] == $past(operand[DATA_W-1:16])));
endmodule

bind shift_rot_unit srot_checker u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opCode(opCode), .sizeSel(sizeSel),
  .operand(operand), .carryIn(carryIn), .zeroIn(zeroIn), .signIn(signIn),
  .countSel(countSel), .countImm(countImm), .countRegLow(countRegLow),
  .outValid(outValid), .result(result), .carryOut(carryOut),
  .zeroOut(zeroOut), .signOut(signOut)
);

// File: tb/shift_rot_unit_bench.sv
module shift_rot_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  opCode = '0;
  logic [1:0]  sizeSel = '0;
  logic [31:0] operand = '0;
  logic        carryIn = 1'b0, zeroIn = 1'b0, signIn = 1'b0, countSel = 1'b0;
  logic [7:0]  countImm = '0, countRegLow = '0;
  logic        outValid, carryOut, zeroOut, signOut;
  logic [31:0] result;

  int checkCnt = 0;
  int failCnt  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  shift_rot_unit u_shift_rot_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opCode(opCode), .sizeSel(sizeSel),
    .operand(operand), .carryIn(carryIn), .zeroIn(zeroIn), .signIn(signIn),
    .countSel(countSel), .countImm(countImm), .countRegLow(countRegLow),
    .outValid(outValid), .result(result), .carryOut(carryOut),
    .zeroOut(zeroOut), .signOut(signOut)
  );

  typedef struct packed {
    logic [7:0]  tag;
    logic [2:0]  op;
    logic [1:0]  size;
    logic        cin, zin, sin, sel;
    logic [7:0]  imm;
    logic [7:0]  creg;
    logic [31:0] opnd;
    logic [31:0] expRes;
    logic [2:0]  expFlags; // {carry, zero, sign}
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{8'd2,  3'd4, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2,    8'h00, 32'h0000_0003, 32'h0000_000C, 3'b000}, // R2 times four
    '{8'd2,  3'd4, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1,    8'h00, 32'h8000_0001, 32'h0000_0002, 3'b100}, // R2 carry out
    '{8'd3,  3'd5, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1,    8'h00, 32'hAABB_CC81, 32'hAABB_CC40, 3'b100}, // R3 byte
    '{8'd4,  3'd7, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 8'd4,    8'h00, 32'hFFFF_FF00, 32'hFFFF_FFF0, 3'b001}, // R4 divide by 16
    '{8'd4,  3'd7, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd20,   8'h00, 32'h1234_8000, 32'h1234_FFFF, 3'b101}, // R4 count above width
    '{8'd5,  3'd1, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 8'd16,   8'h00, 32'h1234_5678, 32'h5678_1234, 3'b011}, // R5 word swap, R8
    '{8'd5,  3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1,    8'h00, 32'h0000_0081, 32'h0000_0003, 3'b100}, // R5
    '{8'd5,  3'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd9,    8'h00, 32'h1122_3381, 32'h1122_3303, 3'b110}, // R5 modulo, R8
    '{8'd6,  3'd2, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd1,    8'h00, 32'h0000_0080, 32'h0000_0000, 3'b101}, // R6 rcl
    '{8'd6,  3'd3, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 8'd1,    8'h00, 32'h0000_0001, 32'h0000_0080, 3'b111}, // R6 rcr
    '{8'd6,  3'd2, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd9,    8'h00, 32'h0000_005A, 32'h0000_005A, 3'b100}, // R6 full ring
    '{8'd6,  3'd3, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1,    8'h00, 32'h0000_0002, 32'h8000_0001, 3'b000}, // R6 dword
    '{8'd9,  3'd5, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 8'd1,    8'h24, 32'hF000_0000, 32'h0F00_0000, 3'b000}, // R9 register count
    '{8'd7,  3'd4, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd16,   8'h00, 32'hABCD_8001, 32'hABCD_0000, 3'b110}, // R7 R2 all out
    '{8'd10, 3'd4, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 8'h20,   8'h00, 32'h1234_5678, 32'h1234_5678, 3'b110}, // R10
    '{8'd7,  3'd6, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1,    8'h00, 32'h0000_0040, 32'h0000_0080, 3'b001}, // R7 sign
    '{8'd11, 3'd5, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1,    8'h00, 32'hFF00_0001, 32'hFF00_0000, 3'b110}, // R11 R7 zero
    '{8'd9,  3'd4, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 8'h23,   8'h00, 32'h0000_0001, 32'h0000_0008, 3'b000}  // R9 mask
  };

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
  endtask

  initial begin
    logic [31:0] heldRes;
    repeat (3) @(negedge clk);
    // R12 reset values
    check(12, "outValid in reset", {31'b0, outValid}, 32'd0);
    check(12, "result in reset", result, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(12, "flags after reset", {29'b0, carryOut, zeroOut, signOut}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      opCode = VECS[v].op; sizeSel = VECS[v].size; operand = VECS[v].opnd;
      carryIn = VECS[v].cin; zeroIn = VECS[v].zin; signIn = VECS[v].sin;
      countSel = VECS[v].sel; countImm = VECS[v].imm; countRegLow = VECS[v].creg;
      inValid = 1'b1;
      @(negedge clk);
      inValid = 1'b0;
      check(1, "outValid", {31'b0, outValid}, 32'd1);
      check(int'(VECS[v].tag), "result", result, VECS[v].expRes);
      check(int'(VECS[v].tag), "flags CZS", {29'b0, carryOut, zeroOut, signOut},
            {29'b0, VECS[v].expFlags});
    end

    // R1 outputs hold while idle, even if inputs move
    heldRes = result;
    operand = 32'hDEAD_BEEF; countImm = 8'd3; carryIn = 1'b1;
    repeat (2) @(negedge clk);
    check(1, "outValid idle", {31'b0, outValid}, 32'd0);
    check(1, "result held", result, heldRes);

    // R1 back-to-back requests each appear one clock later
    opCode = 3'd4; sizeSel = 2'd2; countSel = 1'b0; countImm = 8'd1;
    operand = 32'h0000_0001; inValid = 1'b1;
    @(negedge clk);
    operand = 32'h0000_0010;
    check(1, "first of pair", result, 32'h0000_0002);
    @(negedge clk);
    inValid = 1'b0;
    check(1, "second of pair", result, 32'h0000_0020);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL R1 watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end
endmodule